// File: doc/BRIEF.md
# Key-Protected Sequence Table Guard

This block stands between a simple word-addressed register bus and the instruction table of a flash command sequencer. The table holds 32 sequences of four 32-bit words, 128 words in all. Software may change the table only while it is open; opening or sealing it takes two register writes in a row. First the host writes a fixed 32-bit key, which arms the guard. Then it writes a command word that either seals or opens the table.

The guard accepts a command only when the write just before it on the bus was the key. Any other register write in between clears the arming. Writes into a sealed table are dropped and raise a sticky violation flag. Reads of the table are always served. The seal state, the violation flag and the arming are visible on a status word and as output pins.

Top module: `seq_table_guard`

## Requirements
- R1: After reset the table is open, the violation flag is clear and the guard is not armed, so the status word (word address 2) reads 0 and both `locked_o` and `violation_o` are 0.
- R2: A write of exactly 0x5AF05AF0 to the key word (word address 0) arms the guard. Status bit 2 reads 1 while the guard is armed.
- R3: While the guard is armed, a write of 1 to the command word (word address 1) seals the table and a write of 2 opens it. The command write also clears the arming. Status bit 0 and `locked_o` read 1 while the table is sealed.
- R4: A command write while the guard is not armed leaves the seal state unchanged.
- R5: While the guard is armed, any register write other than the correct key clears the arming and leaves the seal state unchanged. This covers a table write, a status write, a key write with a wrong value, and a command write of a value other than 1 or 2.
- R6: A table write while the table is open stores the data. A read of the same word returns it on `bus_rdata` one cycle after the read request.
- R7: A table write while the table is sealed leaves the word unchanged and sets the violation flag (status bit 1, `violation_o`).
- R8: Reads are served whether the table is open or sealed, and a read never changes the arming.
- R9: Once set, the violation flag stays set through unlock and lock commands until reset.
- R10: The table occupies word addresses 0x100 to 0x17F, and word 0x100 + i holds table word i. Reads of the key word, the command word and any unmapped address return 0. A write to an unmapped address changes no table word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, updated one cycle after a read request and held otherwise |
| locked_o | output | 1 | Table is sealed |
| violation_o | output | 1 | Sticky flag: a write was attempted while the table was sealed |

## Verification
The properties assume a single-word bus with at most one access per cycle. They also assume that `bus_write`, `bus_addr` and `bus_wdata` are meaningful whenever `bus_valid` is high, and that the write strobe has no gaps or retries. Under that assumption, "the previous write" means the previous cycle in which `bus_valid` and `bus_write` were both high. The bench keeps to this contract by driving every access from one task, with a full clock cycle per access and idle cycles in between. The arming rule then depends only on the order of the writes, and idle cycles between the key and the command have no effect.

// File: rtl/tlk_pkg.sv
package tlk_pkg;

   typedef enum logic {
      ARM_IDLE  = 1'b0,
      ARM_KEYED = 1'b1
   } arm_e;

   typedef enum logic {
      TBL_OPEN   = 1'b0,
      TBL_SEALED = 1'b1
   } seal_e;

   typedef struct packed {
      logic key;
      logic cmd;
      logic stat;
      logic tab;
   } sel_t;

   localparam int STAT_SEAL_BIT = 0;
   localparam int STAT_VIOL_BIT = 1;
   localparam int STAT_ARM_BIT  = 2;

endpackage

// File: rtl/tlk_decode.sv
module tlk_decode
   import tlk_pkg::*;
#(
   parameter int ADDR_W     = 9,
   parameter int KEY_ADDR   = 0,
   parameter int CMD_ADDR   = 1,
   parameter int STAT_ADDR  = 2,
   parameter int TAB_BASE   = 256,
   parameter int TAB_WORDS  = 128,
   localparam int IDX_W     = $clog2(TAB_WORDS)
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_t              sel,
   output logic [IDX_W-1:0]  idx
);

   localparam int HI_W = ADDR_W - IDX_W;
   localparam logic [HI_W-1:0] TAB_HI = HI_W'(TAB_BASE >> IDX_W);

   always_comb begin
      sel.key  = (addr == ADDR_W'(KEY_ADDR));
      sel.cmd  = (addr == ADDR_W'(CMD_ADDR));
      sel.stat = (addr == ADDR_W'(STAT_ADDR));
      sel.tab  = (addr[ADDR_W-1:IDX_W] == TAB_HI);
      idx      = addr[IDX_W-1:0];
   end

endmodule

// File: rtl/tlk_keyfsm.sv
module tlk_keyfsm
   import tlk_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter logic [31:0] KEY        = 32'h5AF0_5AF0,
   parameter int          CMD_SEAL   = 1,
   parameter int          CMD_OPEN   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  sel_t              sel,
   input  logic [DATA_W-1:0] wdata,
   output logic              armed,
   output logic              sealed,
   output logic              violation,
   output logic              tab_we
);

   arm_e  arm_q;
   seal_e seal_q;
   logic  viol_q;
   logic  key_ok;

   assign key_ok = sel.key && (wdata == DATA_W'(KEY));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q  <= ARM_IDLE;
         seal_q <= TBL_OPEN;
         viol_q <= 1'b0;
      end else if (wr) begin
         arm_q <= key_ok ? ARM_KEYED : ARM_IDLE;
         if (arm_q == ARM_KEYED && sel.cmd) begin
            if (wdata == DATA_W'(CMD_SEAL))
               seal_q <= TBL_SEALED;
            else if (wdata == DATA_W'(CMD_OPEN))
               seal_q <= TBL_OPEN;
         end
         if (sel.tab && seal_q == TBL_SEALED)
            viol_q <= 1'b1;
      end
   end

   assign armed     = (arm_q == ARM_KEYED);
   assign sealed    = (seal_q == TBL_SEALED);
   assign violation = viol_q;
   assign tab_we    = wr && sel.tab && (seal_q == TBL_OPEN);

endmodule

// File: rtl/tlk_table.sv
module tlk_table #(
   parameter int  DATA_W    = 32,
   parameter int  TAB_WORDS = 128,
   localparam int IDX_W     = $clog2(TAB_WORDS)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rword
);

   logic [DATA_W-1:0] mem [TAB_WORDS];

   always_ff @(posedge clk) begin
      if (we)
         mem[idx] <= wdata;
   end

   assign rword = mem[idx];

endmodule

// File: rtl/seq_table_guard.sv
module seq_table_guard
   import tlk_pkg::*;
#(
   parameter int          ADDR_W        = 9,
   parameter int          DATA_W        = 32,
   parameter int          SEQS          = 32,
   parameter int          WORDS_PER_SEQ = 4,
   parameter int          TAB_BASE      = 256,
   parameter logic [31:0] KEY           = 32'h5AF0_5AF0,
   parameter int          CMD_SEAL      = 1,
   parameter int          CMD_OPEN      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              locked_o,
   output logic              violation_o
);

   localparam int TAB_WORDS = SEQS * WORDS_PER_SEQ;
   localparam int IDX_W     = $clog2(TAB_WORDS);

   // elaboration-time parameter checks
   if (TAB_WORDS != (1 << IDX_W)) begin : g_bad_depth
      $error("table depth must be a power of two");
   end
   if ((TAB_BASE % TAB_WORDS) != 0) begin : g_bad_align
      $error("table base must be aligned to the table size");
   end
   if (TAB_BASE + TAB_WORDS > (1 << ADDR_W)) begin : g_bad_range
      $error("table does not fit in the address space");
   end
   if (TAB_BASE < 4 || ADDR_W <= IDX_W) begin : g_bad_overlap
      $error("table overlaps the control words");
   end
   if (DATA_W != 32) begin : g_bad_width
      $error("key and command words are 32 bits");
   end

   sel_t             sel;
   logic [IDX_W-1:0] tab_idx;
   logic             wr;
   logic             armed_q;
   logic             sealed_q;
   logic             viol_q;
   logic             tab_we;
   logic [DATA_W-1:0] tab_word;
   logic [DATA_W-1:0] stat_word;

   assign wr = bus_valid && bus_write;

   tlk_decode #(
      .ADDR_W    (ADDR_W),
      .KEY_ADDR  (0),
      .CMD_ADDR  (1),
      .STAT_ADDR (2),
      .TAB_BASE  (TAB_BASE),
      .TAB_WORDS (TAB_WORDS)
   ) u_dec (
      .addr (bus_addr),
      .sel  (sel),
      .idx  (tab_idx)
   );

   tlk_keyfsm #(
      .DATA_W   (DATA_W),
      .KEY      (KEY),
      .CMD_SEAL (CMD_SEAL),
      .CMD_OPEN (CMD_OPEN)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr),
      .sel       (sel),
      .wdata     (bus_wdata),
      .armed     (armed_q),
      .sealed    (sealed_q),
      .violation (viol_q),
      .tab_we    (tab_we)
   );

   tlk_table #(
      .DATA_W    (DATA_W),
      .TAB_WORDS (TAB_WORDS)
   ) u_tab (
      .clk   (clk),
      .we    (tab_we),
      .idx   (tab_idx),
      .wdata (bus_wdata),
      .rword (tab_word)
   );

   always_comb begin
      stat_word                = '0;
      stat_word[STAT_SEAL_BIT] = sealed_q;
      stat_word[STAT_VIOL_BIT] = viol_q;
      stat_word[STAT_ARM_BIT]  = armed_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (bus_valid && !bus_write) begin
         if (sel.tab)
            bus_rdata <= tab_word;
         else if (sel.stat)
            bus_rdata <= stat_word;
         else
            bus_rdata <= '0;
      end
   end

   assign locked_o    = sealed_q;
   assign violation_o = viol_q;

endmodule

// File: rtl/tlk_checker.sv
module tlk_checker #(
   parameter int          ADDR_W   = 9,
   parameter int          DATA_W   = 32,
   parameter logic [31:0] KEY      = 32'h5AF0_5AF0,
   parameter int          CMD_SEAL = 1,
   parameter int          CMD_OPEN = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              key_hit,
   input logic              cmd_hit,
   input logic              tab_hit,
   input logic              armed,
   input logic              locked_o,
   input logic              violation_o
);

   logic wr;
   logic key_good;
   assign wr       = bus_valid && bus_write;
   assign key_good = key_hit && (bus_wdata == DATA_W'(KEY));

   a_r2_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && key_good) |=> armed);

   a_r3_seal_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && wr && cmd_hit && bus_wdata == DATA_W'(CMD_SEAL)) |=> locked_o);

   a_r3_open_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && wr && cmd_hit && bus_wdata == DATA_W'(CMD_OPEN)) |=> !locked_o);

   a_r4_cmd_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && wr && cmd_hit) |=> $stable(locked_o));

   a_r5_disarm: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && wr && !key_good) |=> !armed);

   a_r7_sealed_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_o && wr && tab_hit) |=> violation_o);

   a_r8_read_keeps_arm: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write) |=> $stable(armed));

   a_r9_violation_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      violation_o |=> violation_o);

endmodule

bind seq_table_guard tlk_checker #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .KEY      (KEY),
   .CMD_SEAL (CMD_SEAL),
   .CMD_OPEN (CMD_OPEN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_valid   (bus_valid),
   .bus_write   (bus_write),
   .bus_wdata   (bus_wdata),
   .key_hit     (sel.key),
   .cmd_hit     (sel.cmd),
   .tab_hit     (sel.tab),
   .armed       (armed_q),
   .locked_o    (locked_o),
   .violation_o (violation_o)
);

// File: tb/tb_seq_table_guard.sv
`timescale 1ns/1ps
module tb_seq_table_guard;

   localparam logic [31:0] KEY = 32'h5AF0_5AF0;
   localparam int BASE = 256;
   localparam int N    = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [8:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        locked_o;
   logic        violation_o;

   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   always #2 clk = ~clk;

   seq_table_guard dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_valid   (bus_valid),
      .bus_write   (bus_write),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .locked_o    (locked_o),
      .violation_o (violation_o)
   );

   function automatic logic [31:0] pat_a(int i);
      return 32'(i) * 32'h0001_0203 + 32'h1F00_0000;
   endfunction

   function automatic logic [31:0] pat_b(int i);
      return ~pat_a(i) ^ 32'h0000_8000;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic [8:0] a, logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(logic [8:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_valid = 1'b0;
      d = bus_rdata;
   endtask

   task automatic stat_is(string req, logic [31:0] exp);
      logic [31:0] v;
      bus_rd(9'd2, v);
      chk(req, v, exp);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      logic [31:0] v;
      #1;
      do_reset();

      // R1: reset state
      stat_is("R1 status after reset", 32'd0);
      chk("R1 locked_o after reset", 32'(locked_o), 32'd0);
      chk("R1 violation_o after reset", 32'(violation_o), 32'd0);

      // R4: command without key
      bus_wr(9'd1, 32'd1);
      stat_is("R4 seal cmd without key ignored", 32'd0);

      // R6 / R10: fill the whole table while open, read back every word
      for (int i = 0; i < N; i++) bus_wr(9'(BASE + i), pat_a(i));
      for (int i = 0; i < N; i++) begin
         bus_rd(9'(BASE + i), v);
         chk($sformatf("R6 open write/read word %0d", i), v, pat_a(i));
      end

      // R2: key arms; R8: status read keeps arming
      bus_wr(9'd0, KEY);
      stat_is("R2 armed after key", 32'd4);
      // R3: seal
      bus_wr(9'd1, 32'd1);
      stat_is("R3 sealed and disarmed", 32'd1);
      chk("R3 locked_o", 32'(locked_o), 32'd1);

      // R7: sealed writes dropped, violation set; R8 reads while sealed
      for (int i = 0; i < N; i++) bus_wr(9'(BASE + i), pat_b(i));
      for (int i = 0; i < N; i++) begin
         bus_rd(9'(BASE + i), v);
         chk($sformatf("R7 R8 sealed word %0d unchanged", i), v, pat_a(i));
      end
      stat_is("R7 violation set", 32'd3);
      chk("R7 violation_o", 32'(violation_o), 32'd1);

      // R5: table write between key and command
      bus_wr(9'd0, KEY);
      bus_wr(9'(BASE + 7), 32'h1234_5678);
      bus_wr(9'd1, 32'd2);
      stat_is("R5 table write disarms", 32'd3);

      // R5: wrong key between
      bus_wr(9'd0, KEY);
      bus_wr(9'd0, KEY ^ 32'h1);
      bus_wr(9'd1, 32'd2);
      stat_is("R5 wrong key disarms", 32'd3);

      // R5: unknown command value disarms, state unchanged
      bus_wr(9'd0, KEY);
      bus_wr(9'd1, 32'd3);
      stat_is("R5 unknown cmd no change and disarmed", 32'd3);
      bus_wr(9'd1, 32'd2);
      stat_is("R4 open cmd after consumed arm ignored", 32'd3);

      // R5: status write between
      bus_wr(9'd0, KEY);
      bus_wr(9'd2, 32'hFFFF_FFFF);
      bus_wr(9'd1, 32'd2);
      stat_is("R5 status write disarms", 32'd3);

      // R8: repeated key and a read between key and command; R9 sticky
      bus_wr(9'd0, KEY);
      bus_wr(9'd0, KEY);
      bus_rd(9'(BASE), v);
      chk("R8 read between key and cmd", v, pat_a(0));
      bus_wr(9'd1, 32'd2);
      stat_is("R9 opened, violation still set", 32'd2);
      chk("R3 locked_o after open", 32'(locked_o), 32'd0);
      chk("R9 violation_o after open", 32'(violation_o), 32'd1);

      // R6: write after reopening
      bus_wr(9'(BASE + 5), pat_b(5));
      bus_rd(9'(BASE + 5), v);
      chk("R6 write after reopen", v, pat_b(5));

      // R10: address map edges
      bus_rd(9'd3, v);
      chk("R10 unmapped read zero", v, 32'd0);
      bus_rd(9'd0, v);
      chk("R10 key word reads zero", v, 32'd0);
      bus_rd(9'd1, v);
      chk("R10 command word reads zero", v, 32'd0);
      bus_wr(9'h180, 32'hDEAD_BEEF);
      bus_wr(9'h0FF, 32'hCAFE_F00D);
      bus_rd(9'h180, v);
      chk("R10 just past table reads zero", v, 32'd0);
      bus_rd(9'(BASE), v);
      chk("R10 word 0 untouched by unmapped write", v, pat_a(0));
      bus_rd(9'(BASE + N - 1), v);
      chk("R10 last word untouched by unmapped write", v, pat_a(N - 1));

      // R3: seal again, idle cycles between key and command allowed
      bus_wr(9'd0, KEY);
      repeat (4) @(negedge clk);
      bus_wr(9'd1, 32'd1);
      chk("R3 reseal after idle gap", 32'(locked_o), 32'd1);

      // R1 / R9: reset clears everything
      do_reset();
      stat_is("R1 R9 status cleared by reset", 32'd0);
      chk("R1 locked_o after second reset", 32'(locked_o), 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule